// File: doc/BRIEF.md
# Sponge Hash Absorb/Squeeze Sequencer

This block drives a 320-bit permutation core to produce a 256-bit message digest in sponge fashion. The permutation itself lives outside: the sequencer presents the full state on a bus, pulses a start strobe, and waits for a done strobe that returns the permuted state. The sequencer holds the state register, loads a fixed initial value, pads and absorbs the message, and then squeezes the digest.

The message arrives as 64-bit blocks on a valid/ready stream. The first byte of a block travels in bits 63:56. The final block carries a byte count of 0 to 8. A 64-bit block is XORed into two separate 32-bit rate slices of the state: the upper halves of lanes A and C. The digest leaves as four 64-bit words on a second valid/ready stream, and the receiver can hold that stream off. After the fourth word is accepted, the sequencer reloads the initial value on its own and becomes ready for the next message.

The state is five 64-bit lanes A, B, C, D, E. A occupies bits 319:256 of the state bus and E occupies bits 63:0. Byte k of a lane is bits 8k+7:8k.

Top module: `hs_sponge_seq`

## Requirements
- R1: At the start of each hash, the first permutation receives a state in which lane B is 0x8040400000000000 (bytes 7, 6, 5 = 0x80, 0x40, 0x40) and every other bit is zero.
- R2: An absorbed block XORs block bits 63:32 into A[63:32] and block bits 31:0 into C[63:32]. All other state bits are left unchanged, and one permutation follows each absorbed block.
- R3: In a final block with n valid bytes (n from 0 to 7), the first n bytes (counted from bits 63:56 downward) are kept. Byte n becomes 0x80, and every byte after it becomes zero. The content of the input bytes at positions n and above has no effect on the digest.
- R4: A final block with byte count 8 is absorbed unchanged and is followed by an extra block 0x8000000000000000, which gets its own permutation.
- R5: A message whose only block is marked last with byte count 0 absorbs exactly one block, equal to 0x8000000000000000.
- R6: Squeezing emits four words with one permutation between consecutive words and none after the fourth. A hash of b absorbed blocks, padding block included, therefore makes 1 + b + 3 permutation calls.
- R7: Each digest word is {A[63:32], C[63:32]} of the current state. Words are emitted in order H0, H1, H2, H3, and dig_last is high only with H3.
- R8: While dig_valid is high and dig_ready is low, dig_valid stays high and dig_data and dig_last stay unchanged.
- R9: perm_start is a one-cycle pulse. From the pulse until perm_done, perm_state_o does not change, and neither stream accepts or offers data.
- R10: After H3 is accepted, the sequencer starts the next hash with the R1 load without any external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message block valid |
| msg_ready | output | 1 | Sequencer can take a message block |
| msg_data | input | 64 | Message block, first byte in bits 63:56 |
| msg_last | input | 1 | Block is the final one of the message |
| msg_bytes | input | 4 | Valid byte count of the final block (0 to 8) |
| dig_valid | output | 1 | Digest word valid |
| dig_ready | input | 1 | Receiver takes the digest word |
| dig_data | output | 64 | Digest word |
| dig_last | output | 1 | Word is H3 |
| perm_start | output | 1 | Start pulse to the permutation core |
| perm_state_o | output | 320 | State presented to the permutation core |
| perm_done | input | 1 | Permutation result valid (one cycle) |
| perm_state_i | input | 320 | Permuted state from the core |

## Verification
The bench builds the block with its default of four squeeze words. It attaches a stand-in permutation (a rotation XOR a constant) with a latency of several cycles, so every handshake wait path is exercised. Because the stand-in is invertible and spreads bits across lanes, a wrong rate slice, a dropped or extra padding block, or a miscounted squeeze changes the digest words. The bench covers empty, partial, full and multi-block messages, final blocks carrying garbage bytes, and a stalled receiver.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int LANE_W    = 64;
    localparam int NUM_LANES = 5;
    localparam int STATE_W   = LANE_W * NUM_LANES;
    localparam int HALF_W    = LANE_W / 2;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        lane_t a;
        lane_t b;
        lane_t c;
        lane_t d;
        lane_t e;
    } sponge_st_t;

    typedef enum logic [2:0] {
        SQ_LOAD,
        SQ_KICK,
        SQ_WAIT,
        SQ_MSG,
        SQ_PAD,
        SQ_OUT
    } seq_st_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_IV,
        OP_ABSORB,
        OP_CAPTURE
    } st_op_t;

    localparam lane_t IV_LANE_B  = 64'h8040_4000_0000_0000;
    localparam lane_t PAD_MARK   = {1'b1, {(LANE_W-1){1'b0}}};
    localparam lane_t ALL_ONES   = {LANE_W{1'b1}};

    function automatic sponge_st_t iv_state();
        sponge_st_t s;
        s   = '0;
        s.b = IV_LANE_B;
        return s;
    endfunction

    function automatic sponge_st_t mix_rate(sponge_st_t s, lane_t w);
        sponge_st_t r;
        r = s;
        r.a[LANE_W-1:HALF_W] = s.a[LANE_W-1:HALF_W] ^ w[LANE_W-1:HALF_W];
        r.c[LANE_W-1:HALF_W] = s.c[LANE_W-1:HALF_W] ^ w[HALF_W-1:0];
        return r;
    endfunction

    function automatic lane_t rate_of(sponge_st_t s);
        return {s.a[LANE_W-1:HALF_W], s.c[LANE_W-1:HALF_W]};
    endfunction

endpackage

// File: rtl/hs_pad.sv
module hs_pad
    import hs_pkg::*;
(
    input  lane_t       raw,
    input  logic        last,
    input  logic [3:0]  nbytes,
    output lane_t       blk,
    output logic        need_extra
);
    logic [5:0] cut;

    always_comb begin
        cut        = {nbytes[2:0], 3'b000};
        blk        = raw;
        need_extra = 1'b0;
        if (last) begin
            if (nbytes >= 4'd8) begin
                need_extra = 1'b1;
            end else begin
                blk = (raw & ~(ALL_ONES >> cut)) | (PAD_MARK >> cut);
            end
        end
    end
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_pkg::*;
#(
    parameter int NUM_SQUEEZE = 4,
    localparam int CNT_W = (NUM_SQUEEZE > 1) ? $clog2(NUM_SQUEEZE) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    msg_valid,
    input  logic    msg_last,
    input  logic    need_extra,
    input  logic    perm_done,
    input  logic    dig_ready,
    output st_op_t  op,
    output logic    pad_only,
    output logic    perm_start,
    output logic    msg_ready,
    output logic    dig_valid,
    output logic    dig_last
);
    seq_st_t          cur, nxt, ret, ret_nxt;
    logic [CNT_W-1:0] sq_cnt, sq_cnt_nxt;
    logic             final_word;

    assign final_word = (sq_cnt == CNT_W'(NUM_SQUEEZE - 1));

    always_comb begin
        nxt        = cur;
        ret_nxt    = ret;
        sq_cnt_nxt = sq_cnt;
        op         = OP_HOLD;
        pad_only   = 1'b0;
        perm_start = 1'b0;
        msg_ready  = 1'b0;
        dig_valid  = 1'b0;
        dig_last   = 1'b0;
        case (cur)
            SQ_LOAD: begin
                op      = OP_IV;
                nxt     = SQ_KICK;
                ret_nxt = SQ_MSG;
            end
            SQ_KICK: begin
                perm_start = 1'b1;
                nxt        = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (perm_done) begin
                    op  = OP_CAPTURE;
                    nxt = ret;
                end
            end
            SQ_MSG: begin
                msg_ready = 1'b1;
                if (msg_valid) begin
                    op  = OP_ABSORB;
                    nxt = SQ_KICK;
                    if (!msg_last)      ret_nxt = SQ_MSG;
                    else if (need_extra) ret_nxt = SQ_PAD;
                    else                 ret_nxt = SQ_OUT;
                end
            end
            SQ_PAD: begin
                op       = OP_ABSORB;
                pad_only = 1'b1;
                nxt      = SQ_KICK;
                ret_nxt  = SQ_OUT;
            end
            SQ_OUT: begin
                dig_valid = 1'b1;
                dig_last  = final_word;
                if (dig_ready) begin
                    if (final_word) begin
                        sq_cnt_nxt = '0;
                        nxt        = SQ_LOAD;
                    end else begin
                        sq_cnt_nxt = sq_cnt + 1'b1;
                        nxt        = SQ_KICK;
                        ret_nxt    = SQ_OUT;
                    end
                end
            end
            default: nxt = SQ_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= SQ_LOAD;
            ret    <= SQ_MSG;
            sq_cnt <= '0;
        end else begin
            cur    <= nxt;
            ret    <= ret_nxt;
            sq_cnt <= sq_cnt_nxt;
        end
    end
endmodule

// File: rtl/hs_state.sv
module hs_state
    import hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  st_op_t     op,
    input  lane_t      word,
    input  sponge_st_t perm_in,
    output sponge_st_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (op)
                OP_IV:      st <= iv_state();
                OP_ABSORB:  st <= mix_rate(st, word);
                OP_CAPTURE: st <= perm_in;
                default:    st <= st;
            endcase
        end
    end
endmodule

// File: rtl/hs_sponge_seq.sv
module hs_sponge_seq
    import hs_pkg::*;
#(
    parameter int NUM_SQUEEZE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_valid,
    output logic               msg_ready,
    input  logic [LANE_W-1:0]  msg_data,
    input  logic               msg_last,
    input  logic [3:0]         msg_bytes,
    output logic               dig_valid,
    input  logic               dig_ready,
    output logic [LANE_W-1:0]  dig_data,
    output logic               dig_last,
    output logic               perm_start,
    output logic [STATE_W-1:0] perm_state_o,
    input  logic               perm_done,
    input  logic [STATE_W-1:0] perm_state_i
);
    st_op_t     op;
    logic       pad_only;
    logic       need_extra;
    lane_t      padded;
    lane_t      word;
    sponge_st_t st;

    hs_pad u_pad (
        .raw        (msg_data),
        .last       (msg_last),
        .nbytes     (msg_bytes),
        .blk        (padded),
        .need_extra (need_extra)
    );

    hs_ctrl #(.NUM_SQUEEZE(NUM_SQUEEZE)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (msg_valid),
        .msg_last   (msg_last),
        .need_extra (need_extra),
        .perm_done  (perm_done),
        .dig_ready  (dig_ready),
        .op         (op),
        .pad_only   (pad_only),
        .perm_start (perm_start),
        .msg_ready  (msg_ready),
        .dig_valid  (dig_valid),
        .dig_last   (dig_last)
    );

    assign word = pad_only ? PAD_MARK : padded;

    hs_state u_state (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .word    (word),
        .perm_in (sponge_st_t'(perm_state_i)),
        .st      (st)
    );

    assign perm_state_o = st;
    assign dig_data     = rate_of(st);
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk #(
    parameter int STATE_W = 320,
    parameter int LANE_W  = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               msg_ready,
    input logic               dig_valid,
    input logic               dig_ready,
    input logic [LANE_W-1:0]  dig_data,
    input logic               dig_last,
    input logic               perm_start,
    input logic               perm_done,
    input logic [STATE_W-1:0] perm_state_o
);
    logic busy;

    always_ff @(posedge clk) begin
        if (rst)             busy <= 1'b0;
        else if (perm_start) busy <= 1'b1;
        else if (perm_done)  busy <= 1'b0;
    end

    p_start_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        perm_start |=> !perm_start);

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!msg_ready && !dig_valid && !perm_start));

    p_busy_stable_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(perm_state_o));

    p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
        (dig_valid && !dig_ready) |=> (dig_valid && $stable(dig_data) && $stable(dig_last)));

    p_phase_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(msg_ready && dig_valid));
endmodule

bind hs_sponge_seq hs_seq_chk #(.STATE_W(320), .LANE_W(64)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .msg_ready    (msg_ready),
    .dig_valid    (dig_valid),
    .dig_ready    (dig_ready),
    .dig_data     (dig_data),
    .dig_last     (dig_last),
    .perm_start   (perm_start),
    .perm_done    (perm_done),
    .perm_state_o (perm_state_o)
);

// File: tb/sim_hs_sponge_seq.sv
module sim_hs_sponge_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PERM_LAT   = 4;
    localparam logic [319:0] IV_EXP = {64'h0, 64'h8040_4000_0000_0000, 192'h0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [63:0]  msg_data = '0;
    logic         msg_last = 1'b0;
    logic [3:0]   msg_bytes = '0;
    logic         dig_valid;
    logic         dig_ready = 1'b0;
    logic [63:0]  dig_data;
    logic         dig_last;
    logic         perm_start;
    logic [319:0] perm_state_o;
    logic         perm_done;
    logic [319:0] perm_state_i;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_sponge_seq u0 (
        .clk(clk), .rst(rst),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
        .msg_last(msg_last), .msg_bytes(msg_bytes),
        .dig_valid(dig_valid), .dig_ready(dig_ready), .dig_data(dig_data),
        .dig_last(dig_last),
        .perm_start(perm_start), .perm_state_o(perm_state_o),
        .perm_done(perm_done), .perm_state_i(perm_state_i)
    );

    function automatic logic [319:0] tperm(input logic [319:0] s);
        return {s[306:0], s[319:307]} ^ {5{64'h9E37_79B9_7F4A_7C15}};
    endfunction

    function automatic logic [319:0] inject(input logic [319:0] s, input logic [63:0] w);
        logic [319:0] r;
        r = s;
        r[319:288] = s[319:288] ^ w[63:32];
        r[191:160] = s[191:160] ^ w[31:0];
        return r;
    endfunction

    function automatic logic [63:0] pad_blk(input logic [63:0] raw, input int n);
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < n; k++) r[63-8*k -: 8] = raw[63-8*k -: 8];
        r[63-8*n -: 8] = 8'h80;
        return r;
    endfunction

    // stand-in permutation core
    logic [319:0] cap;
    int           cnt;
    int           nstart;
    logic [319:0] last_start;
    logic         r9_bad;
    always @(posedge clk) begin
        perm_done <= 1'b0;
        if (rst) begin
            cnt <= 0; nstart <= 0; r9_bad <= 1'b0;
            perm_state_i <= '0;
        end else if (perm_start) begin
            cap        <= perm_state_o;
            last_start <= perm_state_o;
            nstart     <= nstart + 1;
            cnt        <= PERM_LAT;
        end else if (cnt > 1) begin
            cnt <= cnt - 1;
            if (perm_state_o != cap) r9_bad <= 1'b1;
        end else if (cnt == 1) begin
            perm_done    <= 1'b1;
            perm_state_i <= tperm(cap);
            cnt          <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [319:0] act, input logic [319:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [63:0] msgbuf [0:7];
    int          hash_base = 0;

    task automatic run_hash(input int nblk, input int lastbytes, input int stall, input string tag);
        logic [319:0] s;
        logic [63:0]  w [0:3];
        int           blocks;
        logic [63:0]  held;
        // expected model
        s = tperm(IV_EXP);
        for (int i = 0; i < nblk; i++) begin
            if (i < nblk - 1 || lastbytes == 8) s = inject(s, msgbuf[i]);
            else                                 s = inject(s, pad_blk(msgbuf[i], lastbytes));
            s = tperm(s);
        end
        blocks = nblk;
        if (lastbytes == 8) begin
            s = inject(s, 64'h8000_0000_0000_0000);
            s = tperm(s);
            blocks++;
        end
        for (int j = 0; j < 4; j++) begin
            w[j] = {s[319:288], s[191:160]};
            if (j < 3) s = tperm(s);
        end
        // first permutation of this hash sees the initial value (R1, R10)
        @(negedge clk);
        while (nstart <= hash_base) @(negedge clk);
        check(last_start == IV_EXP, {tag, " R1 R10 init load"}, last_start, IV_EXP);
        // drive blocks
        for (int i = 0; i < nblk; i++) begin
            while (!msg_ready) @(negedge clk);
            msg_valid = 1'b1;
            msg_data  = msgbuf[i];
            msg_last  = (i == nblk - 1);
            msg_bytes = 4'(lastbytes);
            @(negedge clk);
            msg_valid = 1'b0;
            msg_last  = 1'b0;
        end
        // squeeze
        for (int j = 0; j < 4; j++) begin
            while (!dig_valid) @(negedge clk);
            if (stall > 0) begin
                held = dig_data;
                for (int k = 0; k < stall; k++) @(negedge clk);
                check(dig_valid && dig_data == held, {tag, " R8 hold under stall"},
                      {255'h0, dig_valid, dig_data}, {255'h0, 1'b1, held});
            end
            check(dig_data == w[j], {tag, " R2 R3 R4 R5 R7 digest word"}, {256'h0, dig_data}, {256'h0, w[j]});
            check(dig_last == (j == 3), {tag, " R7 last flag"}, {319'h0, dig_last}, {319'h0, j == 3});
            dig_ready = 1'b1;
            @(negedge clk);
            dig_ready = 1'b0;
        end
        check(!dig_valid, {tag, " R6 no fifth word"}, {319'h0, dig_valid}, 320'h0);
        check(nstart - hash_base == 1 + blocks + 3, {tag, " R6 permutation count"},
              320'(nstart - hash_base), 320'(1 + blocks + 3));
        hash_base = nstart;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        check(!msg_ready && !dig_valid, "R9 reset: streams idle",
              {318'h0, msg_ready, dig_valid}, 320'h0);

        // R5: empty message
        msgbuf[0] = 64'hDEAD_BEEF_0123_4567;
        run_hash(1, 0, 0, "empty");

        // R3: three bytes, garbage in the rest
        msgbuf[0] = 64'h6162_63FF_EE11_2233;
        run_hash(1, 3, 0, "partial3");

        // R3: same three bytes, different garbage -> same digest
        msgbuf[0] = 64'h6162_6300_5A5A_A5A5;
        run_hash(1, 3, 0, "partial3b");

        // R4: full single block
        msgbuf[0] = 64'h0102_0304_0506_0708;
        run_hash(1, 8, 0, "full1");

        // R2: multi-block, last with five bytes
        msgbuf[0] = 64'h1111_2222_3333_4444;
        msgbuf[1] = 64'hAAAA_BBBB_CCCC_DDDD;
        msgbuf[2] = 64'h0F1E_2D3C_4B77_8899;
        run_hash(3, 5, 0, "multi5");

        // R4 R8: two full blocks with receiver stalls
        msgbuf[0] = 64'hFEDC_BA98_7654_3210;
        msgbuf[1] = 64'h0011_2233_4455_6677;
        run_hash(2, 8, 3, "full2stall");

        // R3: seven bytes
        msgbuf[0] = 64'h7766_5544_3322_11C3;
        run_hash(1, 7, 1, "partial7");

        check(!r9_bad, "R9 state stable during permutation", {319'h0, r9_bad}, 320'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule